// File: doc/BRIEF.md
# Transmit Byte Queue with Programmable Fill Flag

This block buffers outgoing bytes between a host-side register writer and a bit serializer. The host pushes one byte per cycle and the serializer pops one byte per cycle. The queue holds 64 bytes and always presents its oldest byte on the read data port. The current fill count is reported on every cycle.

A 4-bit threshold code selects one of sixteen fill levels. The levels are 4 bytes apart, running from 61 bytes for code 0 down to 1 byte for code 15. A registered flag compares the fill count against the selected level. The flag is meant to drive a general-purpose output pin. It tells the host when the queue is close to full, or when only a small margin is left before it runs dry. For example, code 13 gives a level of 9 bytes, which leaves 8 bytes of margin.

Two sticky error bits record a pop from an empty queue and a push into a full queue. A flush input empties the queue and clears both error bits.

Top module: `txq_fifo`

## Requirements
- R1: After reset, level_o is 0, empty_o is 1, full_o is 0, and thr_flag_o, underflow_o and overflow_o are all 0.
- R2: Bytes leave in the order they were accepted. While the queue is not empty, rdata_o shows the oldest accepted byte.
- R3: level_o rises by one on each accepted push and falls by one on each accepted pop. It does not change when an accepted push and an accepted pop fall in the same cycle. empty_o is 1 exactly when level_o is 0, and full_o is 1 exactly when level_o is 64.
- R4: The threshold code thr_sel_i (values 0 to 15) selects a level of 61 - 4*code bytes: code 0 gives 61, code 13 gives 9 and code 15 gives 1.
- R5: thr_flag_o is registered. On each clock edge it takes the value (level before that edge >= selected level). As a result it changes one cycle after the count crosses the level in either direction.
- R6: A push while full_o is 1 is dropped. The stored bytes and the count are unaffected, and overflow_o sets and stays set.
- R7: A pop while empty_o is 1 does nothing to the count, and underflow_o sets and stays set.
- R8: flush_i empties the queue and clears underflow_o and overflow_o at the next edge. A push or pop in the same cycle is ignored.
- R9: If a push and a pop arrive together while full, the pop proceeds and the push is dropped with overflow, so the count becomes 63. If they arrive together while empty, the push proceeds and the pop underflows, so the count becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Empty the queue and clear error bits |
| push_i | input | 1 | Write request from host side |
| wdata_i | input | 8 | Byte to write |
| pop_i | input | 1 | Read request from serializer |
| rdata_o | output | 8 | Oldest byte in the queue |
| thr_sel_i | input | 4 | Threshold code |
| level_o | output | 7 | Current byte count |
| empty_o | output | 1 | Queue holds no bytes |
| full_o | output | 1 | Queue holds 64 bytes |
| thr_flag_o | output | 1 | Registered count-at-or-above-level flag |
| underflow_o | output | 1 | Sticky pop-while-empty error |
| overflow_o | output | 1 | Sticky push-while-full error |

## Verification
A push and a pop can fall in the same cycle. The count then has to stay the same, except at the two ends of the queue, where one of the two requests becomes an error instead. The bench forces both ends on purpose. It fills the queue to 64 and issues push and pop together, then drains it to 0 and does the same. It also mixes random concurrent requests in long runs. A queue model in the bench judges each cycle: it applies the pop before the push, using the fill state from before the edge. The error bits, the count, the head byte and the one-cycle-late threshold flag are all compared against that model.

// File: rtl/txq_fifo_pkg.sv
package txq_fifo_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned DEPTH   = 64;
  localparam int unsigned ADDR_W  = $clog2(DEPTH);
  localparam int unsigned CNT_W   = $clog2(DEPTH + 1);
  localparam int unsigned SEL_W   = 4;
  localparam int unsigned THR_TOP = 61;
  localparam int unsigned THR_STEP = 4;

  function automatic logic [CNT_W-1:0] thr_level(input logic [SEL_W-1:0] code);
    int unsigned v;
    v = THR_TOP - THR_STEP * int'(code);
    return CNT_W'(v);
  endfunction
endpackage

// File: rtl/txq_fifo_mem.sv
module txq_fifo_mem #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/txq_fifo_ctrl.sv
module txq_fifo_ctrl #(
  parameter int unsigned DEPTH  = 64,
  localparam int unsigned ADDR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic              pop_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [ADDR_W-1:0] raddr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              underflow_o,
  output logic              overflow_o
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [ADDR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              uf_q, of_q;
  logic              push_ok, pop_ok;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_FULL);
  assign push_ok = push_i && !full_o && !flush_i;
  assign pop_ok  = pop_i && !empty_o && !flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      uf_q     <= 1'b0;
      of_q     <= 1'b0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      uf_q     <= 1'b0;
      of_q     <= 1'b0;
    end else begin
      if (push_ok) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop_ok)  rd_ptr_q <= rd_ptr_q + 1'b1;
      unique case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      if (push_i && full_o) of_q <= 1'b1;
      if (pop_i && empty_o) uf_q <= 1'b1;
    end
  end

  assign we_o        = push_ok;
  assign waddr_o     = wr_ptr_q;
  assign raddr_o     = rd_ptr_q;
  assign cnt_o       = cnt_q;
  assign underflow_o = uf_q;
  assign overflow_o  = of_q;

  assert_count_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_FULL);
  assert_push_inc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !full_o && !flush_i) |=> cnt_q == $past(cnt_q) + 1'b1);
  assert_both_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !full_o && !empty_o && !flush_i) |=> $stable(cnt_q));
  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !flush_i) |=> (overflow_o && $stable(wr_ptr_q)));
  assert_underflow_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !flush_i) |=> (underflow_o && $stable(rd_ptr_q)));
  assert_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underflow_o && !flush_i) |=> underflow_o);
  assert_flush_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (cnt_q == '0 && !underflow_o && !overflow_o));
endmodule

// File: rtl/txq_fifo_thr.sv
module txq_fifo_thr
  import txq_fifo_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] thr_sel_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             flag_o
);
  logic [CNT_W-1:0] lvl;
  logic             flag_q;

  assign lvl = thr_level(thr_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= (cnt_i >= lvl);
  end

  assign flag_o = flag_q;

  assert_lvl_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl >= CNT_W'(1)) && (lvl <= CNT_W'(THR_TOP)) && (lvl[1:0] == 2'b01));
  assert_flag_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(cnt_i) >= $past(lvl));
  assert_flag_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_o) |-> $past(cnt_i) < $past(lvl));
endmodule

// File: rtl/txq_fifo.sv
module txq_fifo
  import txq_fifo_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [SEL_W-1:0]  thr_sel_i,
  output logic [CNT_W-1:0]  level_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              thr_flag_o,
  output logic              underflow_o,
  output logic              overflow_o
);
  logic              we;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [CNT_W-1:0]  cnt;

  txq_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .we_o        (we),
    .waddr_o     (waddr),
    .raddr_o     (raddr),
    .cnt_o       (cnt),
    .empty_o     (empty_o),
    .full_o      (full_o),
    .underflow_o (underflow_o),
    .overflow_o  (overflow_o)
  );

  txq_fifo_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk_i   (clk_i),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata_i),
    .raddr_i (raddr),
    .rdata_o (rdata_o)
  );

  txq_fifo_thr u_thr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .thr_sel_i (thr_sel_i),
    .cnt_i     (cnt),
    .flag_o    (thr_flag_o)
  );

  assign level_o = cnt;

  assert_full_empty_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(full_o && empty_o));
  assert_full_both_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && pop_i && !flush_i) |=> (overflow_o && level_o == CNT_W'(DEPTH - 1)));
  assert_empty_both_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && push_i && pop_i && !flush_i) |=> (underflow_o && level_o == CNT_W'(1)));
endmodule

// File: tb/tb_txq_fifo.sv
`timescale 1ns/1ps
module tb_txq_fifo;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       flush_i = 1'b0, push_i = 1'b0, pop_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [3:0] thr_sel_i = '0;
  logic [7:0] rdata_o;
  logic [6:0] level_o;
  logic       empty_o, full_o, thr_flag_o, underflow_o, overflow_o;

  txq_fifo dut (.*);

  always #2 clk_i = ~clk_i;

  int checks = 0;
  int errors = 0;
  logic [7:0] q[$];
  bit m_uf = 0, m_of = 0;
  string lvl_tag = "R3";
  string flag_tag = "R5";

  function automatic int exp_level(input int code);
    return 61 - 4 * code;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit ps, input bit pp, input bit [7:0] d, input bit fl);
    bit exp_flag, was_full, was_empty;
    @(negedge clk_i);
    push_i = ps; pop_i = pp; wdata_i = d; flush_i = fl;
    exp_flag = (q.size() >= exp_level(int'(thr_sel_i)));
    @(posedge clk_i);
    if (fl) begin
      q.delete(); m_uf = 0; m_of = 0;
    end else begin
      was_full = (q.size() == 64);
      was_empty = (q.size() == 0);
      if (pp) begin
        if (was_empty) m_uf = 1;
        else void'(q.pop_front());
      end
      if (ps) begin
        if (was_full) m_of = 1;
        else q.push_back(d);
      end
    end
    #1;
    check(fl ? "R8" : lvl_tag, int'(level_o), q.size());
    check("R3 empty", int'(empty_o), int'(q.size() == 0));
    check("R3 full", int'(full_o), int'(q.size() == 64));
    check(flag_tag, int'(thr_flag_o), int'(exp_flag));
    check(fl ? "R8 uf" : "R7", int'(underflow_o), int'(m_uf));
    check(fl ? "R8 of" : "R6", int'(overflow_o), int'(m_of));
    if (q.size() != 0) check("R2", int'(rdata_o), int'(q[0]));
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 100000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int r;
    r = $urandom(32'h5A17);
    repeat (3) @(posedge clk_i);
    #1;
    check("R1 level", int'(level_o), 0);
    check("R1 empty", int'(empty_o), 1);
    check("R1 flag", int'(thr_flag_o), 0);
    @(negedge clk_i) rst_ni = 1'b1;
    #1;
    check("R1 full", int'(full_o), 0);
    check("R1 uf", int'(underflow_o), 0);
    check("R1 of", int'(overflow_o), 0);

    // R5 crossing at code 13 (level 9)
    thr_sel_i = 4'd13;
    for (int i = 0; i < 10; i++) step(1, 0, 8'(i + 8'h30), 0);
    for (int i = 0; i < 4; i++) step(0, 1, 8'h00, 0);
    step(0, 0, 8'h00, 0);

    // R4 sweep of codes at fixed count
    flag_tag = "R4";
    while (q.size() < 33) step(1, 0, 8'($urandom), 0);
    for (int c = 0; c < 16; c++) begin
      thr_sel_i = 4'(c);
      step(0, 0, 8'h00, 0);
      step(0, 0, 8'h00, 0);
    end
    thr_sel_i = 4'd0;
    flag_tag = "R5";

    // R6 fill and overflow, R9 both at full
    while (q.size() < 64) step(1, 0, 8'($urandom), 0);
    step(1, 0, 8'hEE, 0);
    lvl_tag = "R9";
    step(1, 1, 8'hDD, 0);
    lvl_tag = "R3";
    step(0, 0, 8'h00, 0);

    // drain, R7 underflow, R9 both at empty
    while (q.size() > 0) step(0, 1, 8'h00, 0);
    step(0, 1, 8'h00, 0);
    lvl_tag = "R9";
    step(1, 1, 8'hA5, 0);
    lvl_tag = "R3";

    // R8 flush with concurrent push and pop
    step(1, 1, 8'h77, 1);
    step(0, 0, 8'h00, 0);

    // random phases
    for (int ph = 0; ph < 12; ph++) begin
      int pp_bias = (ph % 3 == 0) ? 80 : (ph % 3 == 1) ? 20 : 50;
      thr_sel_i = 4'($urandom_range(0, 15));
      for (int i = 0; i < 250; i++) begin
        bit ps, pp, fl;
        ps = ($urandom_range(0, 99) < pp_bias);
        pp = ($urandom_range(0, 99) < 50);
        fl = ($urandom_range(0, 199) == 0);
        if ($urandom_range(0, 31) == 0) thr_sel_i = 4'($urandom_range(0, 15));
        step(ps, pp, 8'($urandom), fl);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule